// File: doc/BRIEF.md
# Shared Parameter Memory with Sign-Extending Alias Window

This block is a word-organised data memory shared by a host processor and a coprocessor engine. Both sides read and write the same storage array through their own valid/ready request and response channels. The host side is 32 bits wide and reaches the array through two address windows. The plain window gives direct access to every byte of every word. The alias window selects the same words but treats the low 24 bits of each word as a signed parameter. A 32-bit read through the alias returns that field sign-extended. No write through the alias ever touches the top byte.

The engine side is 24 bits wide. It moves only the low three bytes of a word. This lets software pack an 8-bit value in the top byte of a word and a 24-bit parameter in the rest, and still read the parameter as a ready-made signed 32-bit number.

Each port holds a one-entry response register. A request is accepted on a clock edge where both `*_req_valid` and `*_req_ready` are high. Its response is presented on the next cycle. Writes also return a response, with zero data. The response stays valid and stable until `*_rsp_ready` is high at a clock edge. While a response waits with `*_rsp_ready` low, `*_req_ready` is low, so back-pressure on the response side stalls new requests. When `*_rsp_ready` is high, a new request can be accepted in the same cycle that the old response leaves, with no bubble. The storage array has no reset. Only the response state is reset.

Top module: `srx_param_ram`

## Requirements
- R1: While reset is asserted and right after it is released, both response valids are low and both request readies are high.
- R2: Every accepted request on either port, read or write, produces its response in the very next cycle.
- R3: While a response is valid and its `*_rsp_ready` is low, the response data and error flag stay unchanged and `*_req_ready` of that port is low.
- R4: Host address bits [1:0] select the byte offset and bits [AW+1:2] select the word. Bit [AW+2] selects the window: 0 is plain, 1 is alias. The same word index in either window reaches the same stored word.
- R5: `h_size` encodes 0 = 8, 1 = 16, 2 = 24 and 3 = 32 bits. A plain-window read returns the selected bytes, starting at the offset, right-aligned and zero-extended. A plain-window write stores the low bytes of `h_wdata` from the offset upward.
- R6: A 32-bit alias read returns bits [23:0] of the word, with bit 23 copied into bits [31:24]. This holds whether bit 23 is set or clear.
- R7: No host write through the alias window changes byte 3, whatever its size or offset. A 32-bit alias write updates bytes 0 to 2.
- R8: Sub-word alias accesses (8, 16, 24 bits) read and write exactly like the plain window, apart from R7.
- R9: An access is misaligned when it is 16 bits at an odd offset, or 24 or 32 bits at a nonzero offset. A misaligned access returns `h_rsp_err` = 1 with zero data and changes no memory. Aligned accesses return `h_rsp_err` = 0.
- R10: An engine write replaces bytes 0 to 2 of the word with `e_wdata` and keeps byte 3. An engine read returns bits [23:0].
- R11: When both ports write the same word in the same cycle, the engine's bytes 0 to 2 win. A host byte 3 write in that cycle still lands.
- R12: A read in the same cycle as a write to the same word returns the old data. A read accepted in any later cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request can be accepted |
| h_write | input | 1 | Host request is a write |
| h_addr | input | AW+3 | Window bit, word index, byte offset |
| h_size | input | 2 | Access size code |
| h_wdata | input | 32 | Host write data, right-aligned |
| h_rsp_valid | output | 1 | Host response valid |
| h_rsp_ready | input | 1 | Host response taken |
| h_rsp_data | output | 32 | Host read data, right-aligned |
| h_rsp_err | output | 1 | Misaligned access reported |
| e_req_valid | input | 1 | Engine request valid |
| e_req_ready | output | 1 | Engine request can be accepted |
| e_write | input | 1 | Engine request is a write |
| e_addr | input | AW | Engine word index |
| e_wdata | input | 24 | Engine write data |
| e_rsp_valid | output | 1 | Engine response valid |
| e_rsp_ready | input | 1 | Engine response taken |
| e_rsp_data | output | 24 | Engine read data |

## Verification
The bench builds the block with `WORDS` = 64, so the host address is 9 bits wide. With only 64 words, random traffic from both ports keeps landing on words that were written a little earlier, in both windows and at every size and offset. That exposes lane merging, top-byte preservation and stale-read mistakes far more often than a sparse 256-word map would. Directed cases force the same-cycle collisions and held responses that random sequential traffic cannot produce.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B24 = 2'd2,
    SZ_B32 = 2'd3
  } acc_size_e;

  localparam int LANES     = 4;
  localparam int LANE_W    = 8;
  localparam int WORD_W    = LANES * LANE_W;
  localparam int ENG_LANES = 3;
  localparam int ENG_W     = ENG_LANES * LANE_W;
  localparam int OFF_W     = $clog2(LANES);
endpackage

// File: rtl/srx_host_decode.sv
module srx_host_decode
  import srx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW+OFF_W:0]   addr,
  input  logic [1:0]          size,
  input  logic                write,
  input  logic [WORD_W-1:0]   wdata,
  output logic [AW-1:0]       word_idx,
  output logic [OFF_W-1:0]    lane_off,
  output logic                alias_win,
  output logic                misalign,
  output logic [LANES-1:0]    wr_be,
  output logic [WORD_W-1:0]   wr_lanes
);
  logic [LANES-1:0] size_mask;
  logic [LANES-1:0] be_raw;
  logic [LANES-1:0] win_mask;

  always_comb begin
    lane_off  = addr[OFF_W-1:0];
    word_idx  = addr[AW+OFF_W-1:OFF_W];
    alias_win = addr[AW+OFF_W];
    unique case (acc_size_e'(size))
      SZ_B8:  begin size_mask = 4'b0001; misalign = 1'b0;              end
      SZ_B16: begin size_mask = 4'b0011; misalign = lane_off[0];       end
      SZ_B24: begin size_mask = 4'b0111; misalign = (lane_off != '0);  end
      default: begin size_mask = 4'b1111; misalign = (lane_off != '0); end
    endcase
    be_raw   = size_mask << lane_off;
    win_mask = alias_win ? {1'b0, {ENG_LANES{1'b1}}} : {LANES{1'b1}};
    wr_be    = (write && !misalign) ? (be_raw & win_mask) : '0;
    wr_lanes = wdata << {lane_off, 3'b000};
  end
endmodule

// File: rtl/srx_read_format.sv
module srx_read_format
  import srx_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [OFF_W-1:0]  lane_off,
  input  logic [1:0]        size,
  input  logic              alias_win,
  input  logic              misalign,
  output logic [WORD_W-1:0] data
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = word >> {lane_off, 3'b000};
    unique case (acc_size_e'(size))
      SZ_B8:  data = {24'h0, shifted[7:0]};
      SZ_B16: data = {16'h0, shifted[15:0]};
      SZ_B24: data = {8'h0, shifted[23:0]};
      default: data = alias_win ? {{(WORD_W-ENG_W){word[ENG_W-1]}}, word[ENG_W-1:0]}
                                : word;
    endcase
    if (misalign) data = '0;
  end
endmodule

// File: rtl/srx_lane_store.sv
module srx_lane_store
  import srx_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic [LANES-1:0]    h_be,
  input  logic [AW-1:0]       h_idx,
  input  logic [WORD_W-1:0]   h_lanes,
  input  logic                e_we,
  input  logic [AW-1:0]       e_idx,
  input  logic [ENG_W-1:0]    e_data,
  output logic [WORD_W-1:0]   h_rword,
  output logic [WORD_W-1:0]   e_rword
);
  logic same_word;
  assign same_word = (h_idx == e_idx);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [WORDS];
    logic [LANE_W-1:0] e_byte;
    logic              e_hit;

    if (g < ENG_LANES) begin : g_eng
      assign e_byte = e_data[g*LANE_W +: LANE_W];
      assign e_hit  = e_we;
    end else begin : g_host_only
      assign e_byte = '0;
      assign e_hit  = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (e_hit) mem[e_idx] <= e_byte;
      if (h_be[g] && !(e_hit && same_word)) mem[h_idx] <= h_lanes[g*LANE_W +: LANE_W];
    end

    assign h_rword[g*LANE_W +: LANE_W] = mem[h_idx];
    assign e_rword[g*LANE_W +: LANE_W] = mem[e_idx];
  end
endmodule

// File: rtl/srx_resp_slot.sv
module srx_resp_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         can_accept,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (load) begin
        rsp_valid <= 1'b1;
        rsp_data  <= load_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srx_param_ram.sv
module srx_param_ram
  import srx_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req_valid,
  output logic              h_req_ready,
  input  logic              h_write,
  input  logic [AW+2:0]     h_addr,
  input  logic [1:0]        h_size,
  input  logic [31:0]       h_wdata,
  output logic              h_rsp_valid,
  input  logic              h_rsp_ready,
  output logic [31:0]       h_rsp_data,
  output logic              h_rsp_err,
  input  logic              e_req_valid,
  output logic              e_req_ready,
  input  logic              e_write,
  input  logic [AW-1:0]     e_addr,
  input  logic [23:0]       e_wdata,
  output logic              e_rsp_valid,
  input  logic              e_rsp_ready,
  output logic [23:0]       e_rsp_data
);
  localparam int HRSP_W = WORD_W + 1;

  logic                h_fire, e_fire;
  logic [AW-1:0]       hd_idx;
  logic [OFF_W-1:0]    hd_off;
  logic                hd_alias, hd_misalign;
  logic [LANES-1:0]    hd_be;
  logic [WORD_W-1:0]   hd_lanes;
  logic [WORD_W-1:0]   h_rword, e_rword;
  logic [WORD_W-1:0]   h_fmt;
  logic [HRSP_W-1:0]   h_load_data, h_slot_data;
  logic [ENG_W-1:0]    e_load_data;

  assign h_fire = h_req_valid && h_req_ready;
  assign e_fire = e_req_valid && e_req_ready;

  srx_host_decode #(.AW(AW)) i_decode (
    .addr      (h_addr),
    .size      (h_size),
    .write     (h_write),
    .wdata     (h_wdata),
    .word_idx  (hd_idx),
    .lane_off  (hd_off),
    .alias_win (hd_alias),
    .misalign  (hd_misalign),
    .wr_be     (hd_be),
    .wr_lanes  (hd_lanes)
  );

  srx_lane_store #(.WORDS(WORDS), .AW(AW)) i_store (
    .clk     (clk),
    .h_be    (hd_be & {LANES{h_fire}}),
    .h_idx   (hd_idx),
    .h_lanes (hd_lanes),
    .e_we    (e_fire && e_write),
    .e_idx   (e_addr),
    .e_data  (e_wdata),
    .h_rword (h_rword),
    .e_rword (e_rword)
  );

  srx_read_format i_format (
    .word      (h_rword),
    .lane_off  (hd_off),
    .size      (h_size),
    .alias_win (hd_alias),
    .misalign  (hd_misalign),
    .data      (h_fmt)
  );

  assign h_load_data = {hd_misalign, (h_write ? '0 : h_fmt)};
  assign e_load_data = e_write ? '0 : e_rword[ENG_W-1:0];

  srx_resp_slot #(.W(HRSP_W)) i_h_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (h_fire),
    .load_data  (h_load_data),
    .can_accept (h_req_ready),
    .rsp_valid  (h_rsp_valid),
    .rsp_ready  (h_rsp_ready),
    .rsp_data   (h_slot_data)
  );

  assign h_rsp_err  = h_slot_data[HRSP_W-1];
  assign h_rsp_data = h_slot_data[WORD_W-1:0];

  srx_resp_slot #(.W(ENG_W)) i_e_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (e_fire),
    .load_data  (e_load_data),
    .can_accept (e_req_ready),
    .rsp_valid  (e_rsp_valid),
    .rsp_ready  (e_rsp_ready),
    .rsp_data   (e_rsp_data)
  );
endmodule

// File: rtl/srx_param_ram_chk.sv
module srx_param_ram_chk #(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_req_valid,
  input logic          h_req_ready,
  input logic          h_write,
  input logic [AW+2:0] h_addr,
  input logic [1:0]    h_size,
  input logic          h_rsp_valid,
  input logic          h_rsp_ready,
  input logic [31:0]   h_rsp_data,
  input logic          h_rsp_err,
  input logic          e_req_valid,
  input logic          e_req_ready,
  input logic          e_rsp_valid,
  input logic          e_rsp_ready,
  input logic [23:0]   e_rsp_data
);
  logic h_fire, e_fire, h_bad;
  assign h_fire = h_req_valid && h_req_ready;
  assign e_fire = e_req_valid && e_req_ready;
  assign h_bad  = ((h_size == 2'd1) && h_addr[0]) ||
                  ((h_size >= 2'd2) && (h_addr[1:0] != 2'd0));

  a_r2_host_latency: assert property (@(posedge clk) disable iff (!rst_n)
    h_fire |=> h_rsp_valid);

  a_r2_eng_latency: assert property (@(posedge clk) disable iff (!rst_n)
    e_fire |=> e_rsp_valid);

  a_r3_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rsp_valid && !h_rsp_ready) |=>
      (h_rsp_valid && $stable(h_rsp_data) && $stable(h_rsp_err)));

  a_r3_eng_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rsp_valid && !e_rsp_ready) |=> (e_rsp_valid && $stable(e_rsp_data)));

  a_r6_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (h_fire && !h_write && h_addr[AW+2] && (h_size == 2'd3) && (h_addr[1:0] == 2'd0))
      |=> (h_rsp_data[31:24] == {8{h_rsp_data[23]}}));

  a_r9_misalign_err: assert property (@(posedge clk) disable iff (!rst_n)
    (h_fire && h_bad) |=> (h_rsp_err && (h_rsp_data == 32'h0)));

  a_r9_aligned_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (h_fire && !h_bad) |=> !h_rsp_err);
endmodule

bind srx_param_ram srx_param_ram_chk #(.WORDS(WORDS), .AW(AW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .h_req_valid (h_req_valid),
  .h_req_ready (h_req_ready),
  .h_write     (h_write),
  .h_addr      (h_addr),
  .h_size      (h_size),
  .h_rsp_valid (h_rsp_valid),
  .h_rsp_ready (h_rsp_ready),
  .h_rsp_data  (h_rsp_data),
  .h_rsp_err   (h_rsp_err),
  .e_req_valid (e_req_valid),
  .e_req_ready (e_req_ready),
  .e_rsp_valid (e_rsp_valid),
  .e_rsp_ready (e_rsp_ready),
  .e_rsp_data  (e_rsp_data)
);

// File: tb/test_srx_param_ram.sv
`timescale 1ns/1ps
module test_srx_param_ram;
  localparam int WORDS = 64;
  localparam int AW    = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          h_req_valid = 1'b0, h_write = 1'b0, h_rsp_ready = 1'b1;
  logic [AW+2:0] h_addr = '0;
  logic [1:0]    h_size = '0;
  logic [31:0]   h_wdata = '0;
  logic          h_req_ready, h_rsp_valid, h_rsp_err;
  logic [31:0]   h_rsp_data;
  logic          e_req_valid = 1'b0, e_write = 1'b0, e_rsp_ready = 1'b1;
  logic [AW-1:0] e_addr = '0;
  logic [23:0]   e_wdata = '0;
  logic          e_req_ready, e_rsp_valid;
  logic [23:0]   e_rsp_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] mdl [WORDS];

  always #2 clk = ~clk;

  srx_param_ram #(.WORDS(WORDS)) i_srx_param_ram (
    .clk(clk), .rst_n(rst_n),
    .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_write(h_write),
    .h_addr(h_addr), .h_size(h_size), .h_wdata(h_wdata),
    .h_rsp_valid(h_rsp_valid), .h_rsp_ready(h_rsp_ready),
    .h_rsp_data(h_rsp_data), .h_rsp_err(h_rsp_err),
    .e_req_valid(e_req_valid), .e_req_ready(e_req_ready), .e_write(e_write),
    .e_addr(e_addr), .e_wdata(e_wdata),
    .e_rsp_valid(e_rsp_valid), .e_rsp_ready(e_rsp_ready), .e_rsp_data(e_rsp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [1:0] sz, input logic [1:0] off);
    return (sz == 2'd1 && off[0]) || (sz >= 2'd2 && off != 2'd0);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] w, input logic [1:0] off,
                                         input logic [1:0] sz, input bit mir);
    logic [31:0] r;
    r = '0;
    if (is_bad(sz, off)) return r;
    for (int b = 0; b <= int'(sz); b++) r[8*b +: 8] = w[8*(b+int'(off)) +: 8];
    if (sz == 2'd3 && mir) r[31:24] = {8{w[23]}};
    return r;
  endfunction

  function automatic logic [31:0] exp_wr(input logic [31:0] old, input logic [1:0] off,
                                         input logic [1:0] sz, input bit mir, input logic [31:0] wd);
    logic [31:0] n;
    n = old;
    if (is_bad(sz, off)) return n;
    for (int b = 0; b < 4; b++)
      if (b >= int'(off) && b <= int'(off) + int'(sz) && !(mir && b == 3))
        n[8*b +: 8] = wd[8*(b-int'(off)) +: 8];
    return n;
  endfunction

  task automatic host_op(input bit w, input bit mir, input logic [AW-1:0] idx,
                         input logic [1:0] off, input logic [1:0] sz,
                         input logic [31:0] wd, input string req);
    logic [31:0] er;
    @(negedge clk);
    while (!h_req_ready) @(negedge clk);
    er = w ? 32'h0 : exp_rd(mdl[idx], off, sz, mir);
    h_req_valid = 1'b1; h_write = w; h_addr = {mir, idx, off};
    h_size = sz; h_wdata = wd; h_rsp_ready = 1'b1;
    @(negedge clk);
    h_req_valid = 1'b0;
    chk(h_rsp_valid, "R2 host response next cycle", {31'h0, h_rsp_valid}, 32'h1);
    chk(h_rsp_err == is_bad(sz, off), "R9 error flag", {31'h0, h_rsp_err}, {31'h0, is_bad(sz, off)});
    chk(h_rsp_data == er, req, h_rsp_data, er);
    if (w) mdl[idx] = exp_wr(mdl[idx], off, sz, mir, wd);
  endtask

  task automatic eng_op(input bit w, input logic [AW-1:0] idx, input logic [23:0] wd, input string req);
    logic [23:0] er;
    @(negedge clk);
    while (!e_req_ready) @(negedge clk);
    er = w ? 24'h0 : mdl[idx][23:0];
    e_req_valid = 1'b1; e_write = w; e_addr = idx; e_wdata = wd; e_rsp_ready = 1'b1;
    @(negedge clk);
    e_req_valid = 1'b0;
    chk(e_rsp_valid, "R2 engine response next cycle", {31'h0, e_rsp_valid}, 32'h1);
    chk(e_rsp_data == er, req, {8'h0, e_rsp_data}, {8'h0, er});
    if (w) mdl[idx][23:0] = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed_0c3a));
    repeat (3) @(negedge clk);
    chk(!h_rsp_valid && !e_rsp_valid, "R1 valids low in reset", {30'h0, h_rsp_valid, e_rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(h_req_ready && e_req_ready && !h_rsp_valid && !e_rsp_valid, "R1 idle after reset",
        {28'h0, h_req_ready, e_req_ready, h_rsp_valid, e_rsp_valid}, 32'hC);

    // fill memory through the plain window
    for (int i = 0; i < WORDS; i++) host_op(1'b1, 1'b0, AW'(i), 2'd0, 2'd3, $urandom, "R5 fill write");

    // R6: bit 23 set and clear
    host_op(1'b1, 1'b0, 6'd3, 2'd0, 2'd3, 32'hA580_1234, "R5 write");
    host_op(1'b0, 1'b1, 6'd3, 2'd0, 2'd3, 32'h0, "R6 alias read bit23 set");
    chk(mdl[3] == 32'hA580_1234, "R6 model sanity", mdl[3], 32'hA580_1234);
    host_op(1'b1, 1'b0, 6'd4, 2'd0, 2'd3, 32'h5A7F_0001, "R5 write");
    host_op(1'b0, 1'b1, 6'd4, 2'd0, 2'd3, 32'h0, "R6 alias read bit23 clear");
    // R7: alias writes keep byte 3
    host_op(1'b1, 1'b1, 6'd3, 2'd0, 2'd3, 32'h1122_3344, "R7 alias write");
    host_op(1'b0, 1'b0, 6'd3, 2'd0, 2'd3, 32'h0, "R7 byte3 kept after 32-bit alias write");
    chk(mdl[3] == 32'hA522_3344, "R7 expected word", mdl[3], 32'hA522_3344);
    host_op(1'b1, 1'b1, 6'd3, 2'd3, 2'd0, 32'h0000_00EE, "R7 alias byte3 write");
    host_op(1'b0, 1'b0, 6'd3, 2'd3, 2'd0, 32'h0, "R7 byte3 unchanged by alias byte write");
    // R8: sub-word alias same as plain
    host_op(1'b1, 1'b1, 6'd5, 2'd2, 2'd1, 32'h0000_BEEF, "R8 alias halfword write");
    host_op(1'b0, 1'b1, 6'd5, 2'd2, 2'd1, 32'h0, "R8 alias halfword read");
    host_op(1'b0, 1'b0, 6'd5, 2'd1, 2'd0, 32'h0, "R8 plain byte read after alias");
    // R4: alias and plain reach the same word
    host_op(1'b1, 1'b1, 6'd9, 2'd0, 2'd2, 32'h00C0_FFEE, "R4 alias write");
    host_op(1'b0, 1'b0, 6'd9, 2'd0, 2'd3, 32'h0, "R4 plain read of same word");
    // R9: misaligned leaves memory
    host_op(1'b1, 1'b0, 6'd9, 2'd1, 2'd3, 32'hFFFF_FFFF, "R9 misaligned write");
    host_op(1'b1, 1'b1, 6'd9, 2'd3, 2'd1, 32'hFFFF_FFFF, "R9 odd halfword write");
    host_op(1'b0, 1'b0, 6'd9, 2'd0, 2'd3, 32'h0, "R9 memory unchanged");
    host_op(1'b0, 1'b0, 6'd9, 2'd2, 2'd2, 32'h0, "R9 misaligned read data zero");
    // R10: engine
    eng_op(1'b1, 6'd3, 24'h87_6543, "R10 engine write");
    host_op(1'b0, 1'b0, 6'd3, 2'd0, 2'd3, 32'h0, "R10 engine kept byte3");
    eng_op(1'b0, 6'd4, 24'h0, "R10 engine read");

    // R11: same-cycle collision
    @(negedge clk);
    h_req_valid = 1'b1; h_write = 1'b1; h_addr = {1'b0, 6'd12, 2'd0}; h_size = 2'd3; h_wdata = 32'hDEAD_BEEF;
    e_req_valid = 1'b1; e_write = 1'b1; e_addr = 6'd12; e_wdata = 24'h13_5724;
    @(negedge clk);
    h_req_valid = 1'b0; e_req_valid = 1'b0;
    mdl[12] = 32'hDE13_5724;
    host_op(1'b0, 1'b0, 6'd12, 2'd0, 2'd3, 32'h0, "R11 engine wins low bytes, host byte3 lands");

    // R12: read while engine writes
    @(negedge clk);
    h_req_valid = 1'b1; h_write = 1'b0; h_addr = {1'b0, 6'd13, 2'd0}; h_size = 2'd3;
    e_req_valid = 1'b1; e_write = 1'b1; e_addr = 6'd13; e_wdata = 24'hAB_CDEF;
    @(negedge clk);
    h_req_valid = 1'b0; e_req_valid = 1'b0;
    chk(h_rsp_data == mdl[13], "R12 same-cycle read returns old data", h_rsp_data, mdl[13]);
    mdl[13][23:0] = 24'hAB_CDEF;
    host_op(1'b0, 1'b0, 6'd13, 2'd0, 2'd3, 32'h0, "R12 later read returns new data");

    // R3: back-pressure
    @(negedge clk);
    h_rsp_ready = 1'b0;
    h_req_valid = 1'b1; h_write = 1'b0; h_addr = {1'b1, 6'd3, 2'd0}; h_size = 2'd3;
    @(negedge clk);
    h_req_valid = 1'b0;
    held = h_rsp_data;
    chk(h_rsp_valid && !h_req_ready, "R3 stalled response blocks requests",
        {30'h0, h_rsp_valid, h_req_ready}, 32'h2);
    repeat (3) @(negedge clk);
    chk(h_rsp_valid && h_rsp_data == held && !h_req_ready, "R3 response held", h_rsp_data, held);
    chk(held == {{8{mdl[3][23]}}, mdl[3][23:0]}, "R6 held alias read", held, {{8{mdl[3][23]}}, mdl[3][23:0]});
    h_rsp_ready = 1'b1;
    @(negedge clk);
    chk(!h_rsp_valid && h_req_ready, "R3 response released", {30'h0, h_rsp_valid, h_req_ready}, 32'h1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] idx;
      idx = AW'($urandom_range(0, WORDS-1));
      if ($urandom_range(0, 3) == 0)
        eng_op(1'($urandom_range(0, 1)), idx, 24'($urandom), "R10 random engine");
      else
        host_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), idx,
                2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), $urandom,
                "R5 R6 R7 R8 random host");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule